// File: doc/BRIEF.md
# Supply-Fail Reset and Park/Brake Sequencer

This controller takes the digital good/bad flags of three supply monitors (analog, digital and main supply) and turns them into two active-low system reset outputs and an emergency shutdown sequence for a disk-style actuator and spindle. Each supply has two flags. One is the upper flag, above the threshold plus hysteresis. The other is the lower flag, above the bare threshold. Every flag passes through a deglitch filter before it changes the supply's state. Once all three supplies are accepted as good, the resets stay low for a further power-on delay. The delay counts in clock cycles and starts over whenever a fault arrives during the wait.

While the system is held in reset, a park is in force. The actuator latch drivers are disabled at once, and a brake delay counter starts. When the brake delay expires, all low-side spindle pre-drivers are enabled together. Software can also request a park or a brake through two control bits, with no supply fault present. The brake stays on until the resets are released and both software bits are clear.

Top module: `supply_guard_seq`

## Requirements
- R1: After the block's own reset `rstN` is released, both reset outputs are 0, park is active, the latch enable is 0 and the brake is 0. The two reset outputs always carry the same value.
- R2: A supply flag change is accepted only after the flag has held its new value for DEGLITCH consecutive clock edges. A pulse shorter than that leaves the reset outputs unchanged.
- R3: A bad supply becomes good only through its upper flag (`supRiseOk`). A good supply becomes bad only through its lower flag (`supFallOk`). The upper flag alone cannot fail a good supply, and the lower flag alone cannot qualify a bad one.
- R4: If the lower flag of any one supply drops and stays low, both reset outputs go to 0 on clock edge DEGLITCH+1, counting the first edge after the drop as edge 1.
- R5: Suppose all supplies are bad and their upper flags rise. The reset outputs stay 0 through edge DEGLITCH+POR_CYC-1 and become 1 on edge DEGLITCH+POR_CYC.
- R6: A fault accepted during the power-on delay restarts that delay. Release then comes DEGLITCH+POR_CYC edges after the supplies recover, with no early release.
- R7: Whenever the reset outputs are 0, park is active and the latch enable is 0. Both take effect on the same edge on which the reset outputs fall.
- R8: The low-side brake enable rises exactly BRAKE_CYC edges after the park request began, counting the edge that first shows park as edge 1.
- R9: Setting `swPark` while supplies are good sets park active and clears the latch enable on the next edge. The reset outputs stay at 1. The brake follows BRAKE_CYC edges after `swPark` was set.
- R10: Setting `swBrake` turns the brake on at the next clock edge, with no delay, whatever the supply state.
- R11: Park, latch-disable and brake end one edge after the reset outputs are released, provided both software bits are 0. While `swBrake` is 1, the brake holds through the release, and it drops one edge after `swBrake` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer's own registers |
| supRiseOk | input | NUM_SUP | Per-supply upper flag: supply above threshold plus hysteresis |
| supFallOk | input | NUM_SUP | Per-supply lower flag: supply above the bare threshold |
| swPark | input | 1 | Software park request |
| swBrake | input | 1 | Software brake request |
| sysRstN | output | 1 | Active-low system reset, push-pull copy |
| sysRstOdN | output | 1 | Active-low system reset, copy meant for an open-drain pad |
| latchDrvEn | output | 1 | Actuator latch driver enable, 0 during park |
| parkActive | output | 1 | Park sequence in force |
| lowSideBrakeEn | output | 1 | Enables all low-side spindle pre-drivers together |

## Verification
A supply state stuck or flipped inside the deglitch filter shows at `sysRstN` within DEGLITCH+1 edges. A glitch shorter than the window would wrongly pull the reset low, or a real fault would fail to do so. A wrong power-on counter shows as a release that is early or late by a whole number of edges, so the release edge is sampled exactly, both after a clean power-up and after a restart mid-delay. Faults in the park and brake registers show on the edge after the stimulus for latch and park. For the brake they show exactly BRAKE_CYC edges later, and the edges on both sides of each transition are sampled.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  // Strobes issued by the control to the counter datapath.
  typedef struct packed {
    logic porClr;
    logic porInc;
    logic brkClr;
    logic brkInc;
  } sgsStrobe_t;

endpackage

// File: rtl/sgs_datapath.sv
module sgs_datapath
  import sgs_pkg::*;
#(
  parameter int NUM_SUP   = 3,
  parameter int DEGLITCH  = 4,
  parameter int POR_CYC   = 16,
  parameter int BRAKE_CYC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SUP-1:0] supRiseOk,
  input  logic [NUM_SUP-1:0] supFallOk,
  input  sgsStrobe_t         strobe,
  output logic               allGood,
  output logic               porDone,
  output logic               brkDone
);

  localparam int DGW = $clog2(DEGLITCH + 1);
  localparam int PW  = $clog2(POR_CYC + 1);
  localparam int BW  = $clog2(BRAKE_CYC + 1);

  logic [NUM_SUP-1:0] supGood;

  // One hysteresis-aware deglitch filter per supply.
  for (genvar g = 0; g < NUM_SUP; g++) begin : g_filt
    logic [DGW-1:0] stableCnt;
    logic           goodQ;
    logic           target;

    // Good supplies watch the lower flag, bad ones the upper flag.
    assign target     = goodQ ? supFallOk[g] : supRiseOk[g];
    assign supGood[g] = goodQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stableCnt <= '0;
        goodQ     <= 1'b0;
      end else if (target != goodQ) begin
        if (stableCnt == DGW'(DEGLITCH - 1)) begin
          goodQ     <= target;
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + DGW'(1);
        end
      end else begin
        stableCnt <= '0;
      end
    end
  end

  assign allGood = &supGood;

  logic [PW-1:0] porCnt;
  logic [BW-1:0] brkCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              porCnt <= '0;
    else if (strobe.porClr) porCnt <= '0;
    else if (strobe.porInc) porCnt <= porCnt + PW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              brkCnt <= '0;
    else if (strobe.brkClr) brkCnt <= '0;
    else if (strobe.brkInc) brkCnt <= brkCnt + BW'(1);
  end

  assign porDone = allGood && (porCnt == PW'(POR_CYC - 1));
  assign brkDone = (brkCnt == BW'(BRAKE_CYC - 1));

endmodule

// File: rtl/sgs_ctrl.sv
module sgs_ctrl
  import sgs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       allGood,
  input  logic       porDone,
  input  logic       brkDone,
  input  logic       swPark,
  input  logic       swBrake,
  output sgsStrobe_t strobe,
  output logic       rstOut,
  output logic       parkOn,
  output logic       latchEn,
  output logic       brakeOn
);

  logic parkReq;

  // Park is wanted while the system is (or is about to be) held in reset,
  // or on software request.
  assign parkReq = !allGood || !rstOut || swPark;

  always_comb begin
    strobe.porClr = !allGood;
    strobe.porInc = allGood && !rstOut && !porDone;
    strobe.brkClr = !parkReq || brakeOn;
    strobe.brkInc = parkReq && !brakeOn && !brkDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstOut  <= 1'b0;
      parkOn  <= 1'b1;
      latchEn <= 1'b0;
      brakeOn <= 1'b0;
    end else begin
      if (!allGood)                 rstOut <= 1'b0;
      else if (porDone && !rstOut)  rstOut <= 1'b1;

      parkOn  <= parkReq;
      latchEn <= !parkReq;

      if (swBrake || (parkReq && !brakeOn && brkDone)) brakeOn <= 1'b1;
      else if (!parkReq)                              brakeOn <= 1'b0;
    end
  end

endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
  import sgs_pkg::*;
#(
  parameter int NUM_SUP   = 3,
  parameter int DEGLITCH  = 4,
  parameter int POR_CYC   = 16,
  parameter int BRAKE_CYC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SUP-1:0] supRiseOk,
  input  logic [NUM_SUP-1:0] supFallOk,
  input  logic               swPark,
  input  logic               swBrake,
  output logic               sysRstN,
  output logic               sysRstOdN,
  output logic               latchDrvEn,
  output logic               parkActive,
  output logic               lowSideBrakeEn
);

  sgsStrobe_t strobe;
  logic       allGood;
  logic       porDone;
  logic       brkDone;
  logic       rstOut;

  sgs_datapath #(
    .NUM_SUP  (NUM_SUP),
    .DEGLITCH (DEGLITCH),
    .POR_CYC  (POR_CYC),
    .BRAKE_CYC(BRAKE_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .supRiseOk(supRiseOk),
    .supFallOk(supFallOk),
    .strobe   (strobe),
    .allGood  (allGood),
    .porDone  (porDone),
    .brkDone  (brkDone)
  );

  sgs_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .allGood(allGood),
    .porDone(porDone),
    .brkDone(brkDone),
    .swPark (swPark),
    .swBrake(swBrake),
    .strobe (strobe),
    .rstOut (rstOut),
    .parkOn (parkActive),
    .latchEn(latchDrvEn),
    .brakeOn(lowSideBrakeEn)
  );

  assign sysRstN   = rstOut;
  assign sysRstOdN = rstOut;

endmodule

// File: rtl/supply_guard_seq_chk.sv
module supply_guard_seq_chk (
  input logic clk,
  input logic rstN,
  input logic allGood,
  input logic swBrake,
  input logic sysRstN,
  input logic sysRstOdN,
  input logic latchDrvEn,
  input logic parkActive,
  input logic lowSideBrakeEn
);

  p_rst_pair_r1: assert property (@(posedge clk) disable iff (!rstN)
    sysRstN == sysRstOdN);

  p_fault_resets_r4: assert property (@(posedge clk) disable iff (!rstN)
    !allGood |=> !sysRstN);

  p_no_early_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstN) |-> $past(allGood));

  p_reset_parks_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sysRstN |-> (parkActive && !latchDrvEn));

  p_latch_vs_park_r7: assert property (@(posedge clk) disable iff (!rstN)
    latchDrvEn != parkActive);

  p_sw_brake_r10: assert property (@(posedge clk) disable iff (!rstN)
    swBrake |=> lowSideBrakeEn);

endmodule

bind supply_guard_seq supply_guard_seq_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .allGood       (allGood),
  .swBrake       (swBrake),
  .sysRstN       (sysRstN),
  .sysRstOdN     (sysRstOdN),
  .latchDrvEn    (latchDrvEn),
  .parkActive    (parkActive),
  .lowSideBrakeEn(lowSideBrakeEn)
);

// File: tb/supply_guard_seq_bench.sv
module supply_guard_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS  = 3;
  localparam int DG  = 3;
  localparam int POR = 10;
  localparam int BD  = 6;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NS-1:0] supRiseOk;
  logic [NS-1:0] supFallOk;
  logic          swPark;
  logic          swBrake;
  logic          sysRstN;
  logic          sysRstOdN;
  logic          latchDrvEn;
  logic          parkActive;
  logic          lowSideBrakeEn;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_guard_seq #(
    .NUM_SUP(NS), .DEGLITCH(DG), .POR_CYC(POR), .BRAKE_CYC(BD)
  ) u_supply_guard_seq (
    .clk           (clk),
    .rstN          (rstN),
    .supRiseOk     (supRiseOk),
    .supFallOk     (supFallOk),
    .swPark        (swPark),
    .swBrake       (swBrake),
    .sysRstN       (sysRstN),
    .sysRstOdN     (sysRstOdN),
    .latchDrvEn    (latchDrvEn),
    .parkActive    (parkActive),
    .lowSideBrakeEn(lowSideBrakeEn)
  );

  // Expected model: a glitch is accepted once it lasts DG edges.
  function automatic bit expGlitchFaults(int len);
    return len >= DG;
  endfunction

  // Expected model: release edge counted from the recovery stimulus.
  function automatic int expReleaseEdge();
    return DG + POR;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic allUp();
    supRiseOk = '1;
    supFallOk = '1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; supRiseOk = '0; supFallOk = '0; swPark = 1'b0; swBrake = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 sysRstN", sysRstN, 0);
    chk("R1 sysRstOdN", sysRstOdN, 0);
    chk("R1 park", parkActive, 1);
    chk("R1 latch", latchDrvEn, 0);
    chk("R1 brake", lowSideBrakeEn, 0);

    // R3: lower flags alone cannot qualify bad supplies
    supFallOk = '1;
    tick(expReleaseEdge() + 3);
    chk("R3 lower flag alone", sysRstN, 0);

    // R5: power-up release timing
    supRiseOk = '1;
    tick(expReleaseEdge() - 1);
    chk("R5 before release", sysRstN, 0);
    chk("R8 brake on during power-up park", lowSideBrakeEn, 1);
    tick(1);
    chk("R5 release", sysRstN, 1);
    chk("R1 copies equal", sysRstOdN, 1);
    tick(1);
    chk("R11 park cleared", parkActive, 0);
    chk("R11 latch enabled", latchDrvEn, 1);
    chk("R11 brake cleared", lowSideBrakeEn, 0);

    // R3: upper flag alone cannot fail a good supply
    supRiseOk[2] = 1'b0;
    tick(DG + 3);
    chk("R3 upper flag drop ignored", sysRstN, 1);
    supRiseOk[2] = 1'b1;
    tick(1);

    // R4/R7/R8: single supply fault
    supFallOk[1] = 1'b0; supRiseOk[1] = 1'b0;
    tick(DG);
    chk("R4 not yet", sysRstN, 1);
    tick(1);
    chk("R4 reset low", sysRstN, 0);
    chk("R7 park with reset", parkActive, 1);
    chk("R7 latch off with reset", latchDrvEn, 0);
    tick(BD - 2);
    chk("R8 brake not yet", lowSideBrakeEn, 0);
    tick(1);
    chk("R8 brake on", lowSideBrakeEn, 1);

    // R6: fault during power-on delay restarts it
    allUp();
    tick(DG + 3);
    supFallOk[0] = 1'b0; supRiseOk[0] = 1'b0;
    tick(DG + 1);
    allUp();
    tick(expReleaseEdge() - 1);
    chk("R6 no early release", sysRstN, 0);
    tick(1);
    chk("R6 release after restart", sysRstN, 1);
    tick(2);

    // R2: random glitches on random supplies
    for (int it = 0; it < 24; it++) begin
      int sup = int'($urandom_range(NS - 1, 0));
      int len = int'($urandom_range(DG + 3, 1));
      int lowSeen = 0;
      supFallOk[sup] = 1'b0;
      for (int c = 0; c < len; c++) begin
        tick(1);
        if (!sysRstN) lowSeen = 1;
      end
      supFallOk[sup] = 1'b1;
      for (int c = 0; c < expReleaseEdge() + 2; c++) begin
        tick(1);
        if (!sysRstN) lowSeen = 1;
      end
      chk("R2 glitch filter", lowSeen, int'(expGlitchFaults(len)));
      chk("R2 recovered", sysRstN, 1);
    end

    // R2 directed: longest ignored glitch
    supFallOk[2] = 1'b0;
    tick(DG - 1);
    supFallOk[2] = 1'b1;
    tick(3);
    chk("R2 DG-1 glitch ignored", sysRstN, 1);

    // R9: software park
    swPark = 1'b1;
    tick(1);
    chk("R9 park", parkActive, 1);
    chk("R9 latch off", latchDrvEn, 0);
    chk("R9 reset untouched", sysRstN, 1);
    tick(BD - 2);
    chk("R9 brake not yet", lowSideBrakeEn, 0);
    tick(1);
    chk("R9 brake on", lowSideBrakeEn, 1);
    swPark = 1'b0;
    tick(1);
    chk("R11 sw park end", parkActive, 0);
    chk("R11 sw park brake end", lowSideBrakeEn, 0);

    // R10: software brake immediate
    swBrake = 1'b1;
    tick(1);
    chk("R10 brake immediate", lowSideBrakeEn, 1);
    chk("R10 no park", parkActive, 0);

    // R11: software brake holds across a fault and release
    supFallOk[2] = 1'b0; supRiseOk[2] = 1'b0;
    tick(DG + 2);
    allUp();
    tick(expReleaseEdge() + 2);
    chk("R11 released", sysRstN, 1);
    chk("R11 brake held by sw", lowSideBrakeEn, 1);
    chk("R11 park ended", parkActive, 0);
    swBrake = 1'b0;
    tick(1);
    chk("R11 brake drops", lowSideBrakeEn, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule